// File: doc/BRIEF.md
# Root Port Interrupt Status and Mask Unit

This unit gathers single-cycle event pulses from a PCIe root port bridge (link loss, hot reset, CRC and streaming faults, configuration timeouts, correctable, non-fatal and fatal error messages, legacy INTx and MSI arrivals, plus AXI-side slave and master faults) into a sticky event register. A separate enable register selects which events may reach the host. One level interrupt line is shared by every cause.

Software reaches the unit over a simple 32-bit register port with a valid/ready handshake. It reads the event register, services the causes it finds, and writes ones to the bits it has handled to clear them. The same port exposes a read-only link-up status bit and a bridge-enable control bit, which the unit drives out to the bridge.

Top module: `rp_irq_status`

## Requirements
- R1: After reset the event register, the enable register and the bridge-enable bit are all zero, `host_irq_o` is low and `reg_ready_o` is low.
- R2: A one on `evt_i` bit b sets event bit b at the next clock edge, and the bit stays set until software clears it. The implemented event bits are 0-3 (link down, CRC error, streaming error, hot reset), 8-11 (config timeout, correctable, non-fatal, fatal), 16 (INTx), 17 (MSI), 20-25 (slave faults) and 26-28 (master faults).
- R3: Event bits outside the implemented set (value 0x1FF30F0F) never set and always read zero.
- R4: A write to byte offset 0x138 clears every event bit whose write-data bit is one. Data bits of zero leave the corresponding event bit unchanged. A read of 0x138 returns the event register.
- R5: If an event pulse and a clear of the same bit fall in the same cycle, the bit ends up set.
- R6: Offset 0x13C is the read/write enable register. Only the bits in 0x1FF30FED are stored, and all other bits read zero.
- R7: `host_irq_o` is high exactly while the bitwise AND of the event and enable registers is nonzero. A change in either register shows on the line in the cycle after the edge that changed it.
- R8: A read of offset 0x144 returns `link_up_i` in bit 11 and zero in every other bit. Writes to 0x144 have no effect.
- R9: Offset 0x148 bit 0 is the read/write bridge-enable bit, which drives `bridge_en_o`. The other bits read zero.
- R10: `reg_ready_o` is high in the cycle after each cycle in which `reg_valid_i` is high, and low otherwise. `reg_rdata_o` carries the read data while ready is high after a read, and is zero in every other cycle.
- R11: Writes to any offset other than 0x138, 0x13C, 0x144 and 0x148 change no state, and reads of such offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 32 | Single-cycle event pulses, one bit per cause |
| link_up_i | input | 1 | Link-up status from the PHY |
| reg_valid_i | input | 1 | Register request valid |
| reg_write_i | input | 1 | High for a write request, low for a read request |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_ready_o | output | 1 | Request completion, one cycle after valid |
| reg_rdata_o | output | 32 | Read data, valid while ready is high |
| bridge_en_o | output | 1 | Bridge-enable control bit |
| host_irq_o | output | 1 | Combined level interrupt to the host |

## Verification
An event pulse and a software clear can hit the same event bit in the same cycle, which is the collision that matters most. The bench drives both on one bit in one cycle, and also a clear of one bit alongside an event on a different bit. It then reads the register back, expecting the pulsed bit set and only the untouched cleared bit gone. A read of the event register can also coincide with a new event. The model expects the read to return the value from before the edge and the next read to show the new bit.

// File: rtl/rp_irq_pkg.sv
package rp_irq_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 12;

    // Register byte offsets
    localparam logic [ADDR_W-1:0] OFS_EVENT  = 12'h138;
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 12'h13C;
    localparam logic [ADDR_W-1:0] OFS_PHY    = 12'h144;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h148;

    localparam int LINK_UP_BIT = 11;
    localparam int BRIDGE_BIT  = 0;

    // Event cause bit positions
    localparam int EV_LINK_LOST   = 0;
    localparam int EV_CRC_BAD     = 1;
    localparam int EV_STREAM_BAD  = 2;
    localparam int EV_HOT_RST     = 3;
    localparam int EV_CFG_TMO     = 8;
    localparam int EV_MSG_CORR    = 9;
    localparam int EV_MSG_NONFTL  = 10;
    localparam int EV_MSG_FATAL   = 11;
    localparam int EV_LEGACY      = 16;
    localparam int EV_MSG_IRQ     = 17;
    localparam int EV_SLV_FIRST   = 20;
    localparam int EV_SLV_COUNT   = 6;
    localparam int EV_MST_FIRST   = 26;
    localparam int EV_MST_COUNT   = 3;

    function automatic logic [REG_W-1:0] event_bits();
        logic [REG_W-1:0] m;
        m = '0;
        m[EV_LINK_LOST]  = 1'b1;
        m[EV_CRC_BAD]    = 1'b1;
        m[EV_STREAM_BAD] = 1'b1;
        m[EV_HOT_RST]    = 1'b1;
        m[EV_CFG_TMO]    = 1'b1;
        m[EV_MSG_CORR]   = 1'b1;
        m[EV_MSG_NONFTL] = 1'b1;
        m[EV_MSG_FATAL]  = 1'b1;
        m[EV_LEGACY]     = 1'b1;
        m[EV_MSG_IRQ]    = 1'b1;
        for (int i = 0; i < EV_SLV_COUNT; i++) m[EV_SLV_FIRST+i] = 1'b1;
        for (int i = 0; i < EV_MST_COUNT; i++) m[EV_MST_FIRST+i] = 1'b1;
        return m;
    endfunction

    localparam logic [REG_W-1:0] EVENT_IMPL  = event_bits();
    localparam logic [REG_W-1:0] ENABLE_IMPL = 32'h1FF3_0FED;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_EVENT,
        SEL_ENABLE,
        SEL_PHY,
        SEL_CTRL
    } reg_sel_e;

endpackage

// File: rtl/rp_irq_events.sv
module rp_irq_events #(
    parameter int                 W    = rp_irq_pkg::REG_W,
    parameter logic [W-1:0]       IMPL = rp_irq_pkg::EVENT_IMPL
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pulse_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flags_o
);

    typedef struct packed {
        logic [W-1:0] flags;
    } ev_state_t;

    ev_state_t    st_d, st_q;
    logic [W-1:0] nxt_d;

    // Per-bit sticky cell; the set term dominates the clear term.
    for (genvar b = 0; b < W; b++) begin : g_bit
        if (IMPL[b]) begin : g_live
            assign nxt_d[b] = pulse_i[b] | (st_q.flags[b] & ~clr_i[b]);

            // R5
            set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                pulse_i[b] |=> flags_o[b]);
            // R2
            sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (flags_o[b] && !clr_i[b]) |=> flags_o[b]);
            // R4
            w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[b] && !pulse_i[b]) |=> !flags_o[b]);
        end else begin : g_hole
            assign nxt_d[b] = 1'b0;
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.flags = nxt_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

endmodule

// File: rtl/rp_irq_regs.sv
module rp_irq_regs
    import rp_irq_pkg::*;
#(
    parameter int                 DW       = REG_W,
    parameter int                 AW       = ADDR_W,
    parameter logic [AW-1:0]      A_EVENT  = OFS_EVENT,
    parameter logic [AW-1:0]      A_ENABLE = OFS_ENABLE,
    parameter logic [AW-1:0]      A_PHY    = OFS_PHY,
    parameter logic [AW-1:0]      A_CTRL   = OFS_CTRL,
    parameter logic [DW-1:0]      EN_IMPL  = ENABLE_IMPL
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic          write_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] flags_i,
    input  logic          link_up_i,
    output logic          ready_o,
    output logic [DW-1:0] rdata_o,
    output logic [DW-1:0] clr_o,
    output logic [DW-1:0] enable_o,
    output logic          bridge_o
);

    typedef struct packed {
        logic [DW-1:0] enable;
        logic          bridge;
        logic          ready;
        logic [DW-1:0] rdata;
    } rf_state_t;

    rf_state_t st_d, st_q;
    reg_sel_e  sel;

    always_comb begin
        if      (addr_i == A_EVENT)  sel = SEL_EVENT;
        else if (addr_i == A_ENABLE) sel = SEL_ENABLE;
        else if (addr_i == A_PHY)    sel = SEL_PHY;
        else if (addr_i == A_CTRL)   sel = SEL_CTRL;
        else                         sel = SEL_NONE;
    end

    always_comb begin
        st_d       = st_q;
        st_d.ready = valid_i;
        st_d.rdata = '0;
        clr_o      = '0;
        if (valid_i && write_i) begin
            case (sel)
                SEL_EVENT:  clr_o       = wdata_i;
                SEL_ENABLE: st_d.enable = wdata_i & EN_IMPL;
                SEL_CTRL:   st_d.bridge = wdata_i[BRIDGE_BIT];
                default:    ;
            endcase
        end else if (valid_i) begin
            case (sel)
                SEL_EVENT:  st_d.rdata                = flags_i;
                SEL_ENABLE: st_d.rdata                = st_q.enable;
                SEL_PHY:    st_d.rdata[LINK_UP_BIT]   = link_up_i;
                SEL_CTRL:   st_d.rdata[BRIDGE_BIT]    = st_q.bridge;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready_o  = st_q.ready;
    assign rdata_o  = st_q.rdata;
    assign enable_o = st_q.enable;
    assign bridge_o = st_q.bridge;

    // R10
    ready_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> ready_o);
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!ready_o && rdata_o == '0));
    // R11
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !write_i && sel == SEL_NONE) |=> rdata_o == '0);
    // R11
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && write_i && sel == SEL_NONE) |=> ($stable(enable_o) && $stable(bridge_o)));
    // R8
    phy_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && write_i && sel == SEL_PHY) |=> ($stable(enable_o) && $stable(bridge_o)));

endmodule

// File: rtl/rp_irq_status.sv
module rp_irq_status
    import rp_irq_pkg::*;
#(
    parameter int DW = REG_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] evt_i,
    input  logic          link_up_i,
    input  logic          reg_valid_i,
    input  logic          reg_write_i,
    input  logic [AW-1:0] reg_addr_i,
    input  logic [DW-1:0] reg_wdata_i,
    output logic          reg_ready_o,
    output logic [DW-1:0] reg_rdata_o,
    output logic          bridge_en_o,
    output logic          host_irq_o
);

    logic [DW-1:0] flags;
    logic [DW-1:0] clr;
    logic [DW-1:0] enable;

    rp_irq_events #(
        .W    (DW),
        .IMPL (EVENT_IMPL)
    ) i_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (evt_i),
        .clr_i   (clr),
        .flags_o (flags)
    );

    rp_irq_regs #(
        .DW (DW),
        .AW (AW)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (reg_valid_i),
        .write_i   (reg_write_i),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .flags_i   (flags),
        .link_up_i (link_up_i),
        .ready_o   (reg_ready_o),
        .rdata_o   (reg_rdata_o),
        .clr_o     (clr),
        .enable_o  (enable),
        .bridge_o  (bridge_en_o)
    );

    assign host_irq_o = |(flags & enable);

    // R7
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_irq_o) |-> $past(reg_valid_i && reg_write_i));
    // R7
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_irq_o) |-> ($past(evt_i != '0) || $past(reg_valid_i && reg_write_i)));

endmodule

// File: tb/test_rp_irq_status.sv
module test_rp_irq_status;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt_i = '0;
    logic        link_up_i = 1'b0;
    logic        reg_valid_i = 1'b0;
    logic        reg_write_i = 1'b0;
    logic [11:0] reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic        reg_ready_o;
    logic [31:0] reg_rdata_o;
    logic        bridge_en_o;
    logic        host_irq_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Behavioural reference state
    bit [31:0] m_ev, m_en, m_rd;
    bit        m_br, m_rdy;

    localparam bit [31:0] EV_OK = 32'h1FF3_0F0F;
    localparam bit [31:0] EN_OK = 32'h1FF3_0FED;

    always #2.5 clk = ~clk;

    rp_irq_status i_rp_irq_status (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .link_up_i(link_up_i),
        .reg_valid_i(reg_valid_i), .reg_write_i(reg_write_i),
        .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_ready_o(reg_ready_o), .reg_rdata_o(reg_rdata_o),
        .bridge_en_o(bridge_en_o), .host_irq_o(host_irq_o)
    );

    task automatic check(input string tag, input string what, input bit [31:0] act, input bit [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        check(tag, "ready", {31'b0, reg_ready_o}, {31'b0, m_rdy});
        check(tag, "rdata", reg_rdata_o, m_rd);
        check(tag, "irq", {31'b0, host_irq_o}, {31'b0, (m_ev & m_en) != 0});
        check(tag, "bridge", {31'b0, bridge_en_o}, {31'b0, m_br});
    endtask

    // One clock: drive at negedge, advance model, compare at next negedge
    task automatic cyc(input bit [31:0] ev, input bit v, input bit w,
                       input bit [11:0] a, input bit [31:0] d, input string tag);
        bit [31:0] clrv;
        evt_i = ev; reg_valid_i = v; reg_write_i = w; reg_addr_i = a; reg_wdata_i = d;
        m_rd = 0;
        clrv = 0;
        if (v && !w) begin
            if (a == 12'h138) m_rd = m_ev;
            else if (a == 12'h13C) m_rd = m_en;
            else if (a == 12'h144) m_rd = link_up_i ? 32'h800 : 32'h0;
            else if (a == 12'h148) m_rd = {31'b0, m_br};
        end
        if (v && w) begin
            if (a == 12'h138) clrv = d;
            else if (a == 12'h13C) m_en = d & EN_OK;
            else if (a == 12'h148) m_br = d[0];
        end
        m_ev  = (m_ev & ~clrv) | (ev & EV_OK);
        m_rdy = v;
        @(posedge clk);
        @(negedge clk);
        evt_i = '0; reg_valid_i = 0; reg_write_i = 0; reg_addr_i = '0; reg_wdata_i = '0;
        compare(tag);
    endtask

    task automatic rd(input bit [11:0] a, input string tag);
        cyc(0, 1, 0, a, 0, tag);
        cyc(0, 0, 0, 0, 0, tag);
    endtask

    task automatic wr(input bit [11:0] a, input bit [31:0] d, input string tag);
        cyc(0, 1, 1, a, d, tag);
    endtask

    initial begin
        #(5ns * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_ev = 0; m_en = 0; m_rd = 0; m_br = 0; m_rdy = 0;
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");
        rd(12'h138, "R1"); rd(12'h13C, "R1"); rd(12'h148, "R1");

        // R2 / R3: every bit position, implemented and reserved
        for (int i = 0; i < 32; i++) begin
            cyc(32'h1 << i, 0, 0, 0, 0, EV_OK[i] ? "R2" : "R3");
            rd(12'h138, EV_OK[i] ? "R2" : "R3");
            wr(12'h138, 32'hFFFF_FFFF, "R4");
        end
        // R3: all pulses at once
        cyc(32'hFFFF_FFFF, 0, 0, 0, 0, "R3");
        rd(12'h138, "R3");

        // R4: zeros no effect, single-bit clear
        wr(12'h138, 32'h0, "R4");
        rd(12'h138, "R4");
        wr(12'h138, 32'h0001_0000, "R4");
        rd(12'h138, "R4");
        wr(12'h138, 32'hFFFF_FFFF, "R4");
        rd(12'h138, "R4");

        // R6: enable register storage
        wr(12'h13C, 32'hFFFF_FFFF, "R6");
        rd(12'h13C, "R6");

        // R7: non-enabled CRC bit, then INTx, then clear and disable
        cyc(32'h2, 0, 0, 0, 0, "R7");
        cyc(32'h1_0000, 0, 0, 0, 0, "R7");
        wr(12'h138, 32'h1_0000, "R7");
        cyc(32'h2_0000, 0, 0, 0, 0, "R7");
        wr(12'h13C, 32'h0, "R7");
        wr(12'h13C, 32'h2_0000, "R7");
        wr(12'h138, 32'hFFFF_FFFF, "R7");

        // R5: set and clear collide on one bit; clear another alongside
        cyc(32'h0800_0000, 0, 0, 0, 0, "R5");
        cyc(32'h1000_0100, 1, 1, 12'h138, 32'h1800_0100, "R5");
        rd(12'h138, "R5");
        // read coincides with a new event
        cyc(32'h8, 1, 0, 12'h138, 0, "R5");
        rd(12'h138, "R5");
        wr(12'h138, 32'hFFFF_FFFF, "R5");

        // R8: phy status
        link_up_i = 1;
        rd(12'h144, "R8");
        wr(12'h144, 32'hFFFF_FFFF, "R8");
        rd(12'h13C, "R8");
        link_up_i = 0;
        rd(12'h144, "R8");

        // R9: bridge enable
        wr(12'h148, 32'hFFFF_FFFF, "R9");
        rd(12'h148, "R9");
        wr(12'h148, 32'hFFFF_FFFE, "R9");
        rd(12'h148, "R9");
        wr(12'h148, 32'h1, "R9");

        // R11: unmapped offsets
        wr(12'h140, 32'hFFFF_FFFF, "R11");
        wr(12'h139, 32'h0, "R11");
        wr(12'h000, 32'h0, "R11");
        cyc(32'h4, 0, 0, 0, 0, "R11");
        wr(12'h13A, 32'hFFFF_FFFF, "R11");
        rd(12'h140, "R11");
        rd(12'h139, "R11");
        rd(12'h13C, "R11");
        rd(12'h138, "R11");
        rd(12'h148, "R11");

        // R10: back-to-back requests and idle cycles
        cyc(0, 1, 0, 12'h13C, 0, "R10");
        cyc(0, 1, 0, 12'h148, 0, "R10");
        cyc(0, 1, 1, 12'h13C, 32'h0, "R10");
        cyc(0, 0, 0, 0, 0, "R10");
        cyc(0, 0, 0, 0, 0, "R10");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule